// File: doc/BRIEF.md
# MDIO Management Master

This block runs clause-22 management transactions on a two-wire MDIO bus on behalf of software. Software reaches it through two 32-bit registers: a data register and a command register. A transaction starts with one write to the command register with the busy bit set. That write carries the direction, the PHY address, the PHY register number and a clock divider select. For a write transaction, software loads the data register first. The block produces the management clock from the system clock. It shifts out a complete frame and, during a read, releases the data pin and captures the PHY's reply. When the frame ends it clears the busy bit. At that point, after a read, the data register holds the reply.

The frame controller is a state machine with five states. `ST_IDLE` waits for a pending command (busy set). `ST_PRE` sends 32 preamble ones. `ST_HDR` sends the start code, the opcode and both addresses (14 bits). `ST_TURN` covers the two turnaround bits. `ST_DATA` moves the 16 data bits. Every transition happens on a falling edge of the management clock, once the phase's bit count is reached: idle to preamble, preamble to header, header to turnaround, turnaround to data, and data back to idle. The move out of idle is the only exception. It happens on the system clock cycle after a command is accepted.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, both register readbacks are zero, the management clock is low and the data pin is released (output enable low).
- R2: The command readback shows busy in bit 0, the direction in bit 1 (1 = write, 0 = read), the register number in bits 8:4, the PHY address in bits 16:12 and the divider select in bits 21:20. All other bits read zero.
- R3: A command write with bit 0 set makes busy read 1 on the next cycle. Busy then clears by itself when the frame ends. A command write with bit 0 clear while idle only updates the fields and starts no frame.
- R4: The divider select s (0..3) sets a management clock period of 16, 32, 64 or 128 system clocks, so each high phase lasts 2^(s+3) system clocks. The clock stays low while no frame is running.
- R5: A write frame lasts 64 management clock periods. It carries, MSB first: 32 ones, start 01, opcode 01, the 5-bit PHY address, the 5-bit register number, turnaround 10 and the 16 data bits from the data register.
- R6: A read frame uses opcode 10. The pin is released for the two turnaround bits and the 16 data bits. Input is sampled on rising management clock edges, and the 16 sampled bits (first sampled = bit 15) appear in data bits 15:0 once busy clears.
- R7: The data pin output and its enable change only while the management clock is low or on its falling edge, never while it is high.
- R8: A command write while busy is set has no effect: the fields and the running frame stay unchanged and no second frame follows.
- R9: Data register bits 31:16 always read zero; bits 15:0 hold the last value written or read.
- R10: When a frame ends, the management clock returns low and the data pin is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = command, 1 = data |
| wr_data | input | 32 | Register write value |
| cmd_rdata | output | 32 | Command register readback |
| data_rdata | output | 32 | Data register readback |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data pin output value |
| mdio_oe | output | 1 | Data pin output enable (1 = drive) |
| mdio_i | input | 1 | Data pin input value |

## Verification
The assertions assume that register writes come from a single master that changes nothing about a frame except through the command and data registers. They also assume the data pin input may take any value at any time, because the checks concern only when the block drives the pin and its clock. The bench's PHY model drives the pin only during the read data phase, changes it only on falling management clock edges, and leaves the pin pulled high otherwise. Any write during a frame is made at least half a period after the frame starts, so it lands while busy is set, as the busy-hold property expects.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_TURN,
        ST_DATA
    } mdio_state_t;

    localparam int ADDR_W    = 5;
    localparam int DIVSEL_W  = 2;
    localparam int MDATA_W   = 16;
    localparam int REG_W     = 32;

    localparam int CMD_BUSY_BIT = 0;
    localparam int CMD_WR_BIT   = 1;
    localparam int CMD_REG_LSB  = 4;
    localparam int CMD_PHY_LSB  = 12;
    localparam int CMD_DIV_LSB  = 20;

    localparam int PRE_LEN   = 32;
    localparam int HDR_LEN   = 4 + 2 * ADDR_W;
    localparam int TURN_LEN  = 2;
    localparam int FRAME_LEN = PRE_LEN + HDR_LEN + TURN_LEN + MDATA_W;
    localparam int SHIFT_LEN = HDR_LEN + TURN_LEN + MDATA_W;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int BASE_LOG2 = 4,
    parameter int SEL_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    localparam int CNT_W = BASE_LOG2 + (1 << SEL_W) - 2;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic             wrap;

    always_comb begin
        lim  = CNT_W'((1 << (BASE_LOG2 - 1 + int'(sel))) - 1);
        wrap = run && (cnt == lim);
        rise_tick = wrap && !mdc;
        fall_tick = wrap && mdc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= !mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic               op_wr,
    input  logic [ADDR_W-1:0]  phy_addr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [MDATA_W-1:0] wdata,
    input  logic               rise_tick,
    input  logic               fall_tick,
    input  logic               mdio_i,
    output logic               run,
    output logic               done,
    output logic [MDATA_W-1:0] rdata,
    output logic               mdio_o,
    output logic               mdio_oe
);
    localparam int CNT_W    = $clog2(FRAME_LEN);
    localparam int PRE_END  = PRE_LEN - 1;
    localparam int HDR_END  = PRE_LEN + HDR_LEN - 1;
    localparam int TURN_END = PRE_LEN + HDR_LEN + TURN_LEN - 1;
    localparam int LAST_BIT = FRAME_LEN - 1;

    mdio_state_t          state, nxt;
    logic [CNT_W-1:0]     bit_cnt;
    logic [SHIFT_LEN-1:0] shreg;
    logic [MDATA_W-1:0]   rdsh;
    logic                 at_pre_end, at_hdr_end, at_turn_end, at_last;

    always_comb begin
        at_pre_end  = fall_tick && (bit_cnt == CNT_W'(PRE_END));
        at_hdr_end  = fall_tick && (bit_cnt == CNT_W'(HDR_END));
        at_turn_end = fall_tick && (bit_cnt == CNT_W'(TURN_END));
        at_last     = fall_tick && (bit_cnt == CNT_W'(LAST_BIT));
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (go)          nxt = ST_PRE;
            ST_PRE:  if (at_pre_end)  nxt = ST_HDR;
            ST_HDR:  if (at_hdr_end)  nxt = ST_TURN;
            ST_TURN: if (at_turn_end) nxt = ST_DATA;
            ST_DATA: if (at_last)     nxt = ST_IDLE;
            default:                  nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            rdsh    <= '0;
        end else begin
            if (state == ST_IDLE) begin
                bit_cnt <= '0;
                if (go)
                    shreg <= {2'b01, (op_wr ? 2'b01 : 2'b10), phy_addr, reg_addr,
                              2'b10, wdata};
            end else if (fall_tick) begin
                bit_cnt <= bit_cnt + 1'b1;
                if (state != ST_PRE)
                    shreg <= {shreg[SHIFT_LEN-2:0], 1'b0};
            end
            if (rise_tick && (state == ST_DATA) && !op_wr)
                rdsh <= {rdsh[MDATA_W-2:0], mdio_i};
        end
    end

    // outputs
    always_comb begin
        mdio_o  = 1'b0;
        mdio_oe = 1'b0;
        unique case (state)
            ST_IDLE: begin
                mdio_o  = 1'b0;
                mdio_oe = 1'b0;
            end
            ST_PRE: begin
                mdio_o  = 1'b1;
                mdio_oe = 1'b1;
            end
            ST_HDR: begin
                mdio_o  = shreg[SHIFT_LEN-1];
                mdio_oe = 1'b1;
            end
            ST_TURN, ST_DATA: begin
                mdio_o  = shreg[SHIFT_LEN-1];
                mdio_oe = op_wr;
            end
            default: begin
                mdio_o  = 1'b0;
                mdio_oe = 1'b0;
            end
        endcase
        run   = (state != ST_IDLE);
        done  = (state == ST_DATA) && at_last;
        rdata = rdsh;
    end
endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
    import mdio_mgmt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_sel,
    input  logic [REG_W-1:0]    wr_data,
    input  logic                done,
    input  logic [MDATA_W-1:0]  rd_result,
    output logic                busy,
    output logic                op_wr,
    output logic [ADDR_W-1:0]   phy_addr,
    output logic [ADDR_W-1:0]   reg_addr,
    output logic [DIVSEL_W-1:0] div_sel,
    output logic [MDATA_W-1:0]  data_q,
    output logic [REG_W-1:0]    cmd_rdata,
    output logic [REG_W-1:0]    data_rdata
);
    logic cmd_wr, accept, start;

    always_comb begin
        cmd_wr = wr_en && !wr_sel;
        accept = cmd_wr && !busy;
        start  = accept && wr_data[CMD_BUSY_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            op_wr    <= 1'b0;
            phy_addr <= '0;
            reg_addr <= '0;
            div_sel  <= '0;
            data_q   <= '0;
        end else begin
            if (accept) begin
                op_wr    <= wr_data[CMD_WR_BIT];
                reg_addr <= wr_data[CMD_REG_LSB +: ADDR_W];
                phy_addr <= wr_data[CMD_PHY_LSB +: ADDR_W];
                div_sel  <= wr_data[CMD_DIV_LSB +: DIVSEL_W];
            end
            if (done)       busy <= 1'b0;
            else if (start) busy <= 1'b1;
            if (done && !op_wr)
                data_q <= rd_result;
            else if (wr_en && wr_sel)
                data_q <= wr_data[MDATA_W-1:0];
        end
    end

    always_comb begin
        cmd_rdata = '0;
        cmd_rdata[CMD_BUSY_BIT]               = busy;
        cmd_rdata[CMD_WR_BIT]                 = op_wr;
        cmd_rdata[CMD_REG_LSB +: ADDR_W]      = reg_addr;
        cmd_rdata[CMD_PHY_LSB +: ADDR_W]      = phy_addr;
        cmd_rdata[CMD_DIV_LSB +: DIVSEL_W]    = div_sel;
        data_rdata = {{(REG_W-MDATA_W){1'b0}}, data_q};
    end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int BASE_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] cmd_rdata,
    output logic [REG_W-1:0] data_rdata,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    logic                busy, op_wr, run, done, go;
    logic                rise_tick, fall_tick;
    logic [ADDR_W-1:0]   phy_addr, reg_addr;
    logic [DIVSEL_W-1:0] div_sel;
    logic [MDATA_W-1:0]  data_q, rd_result;

    assign go = busy;

    mdio_regfile i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .done       (done),
        .rd_result  (rd_result),
        .busy       (busy),
        .op_wr      (op_wr),
        .phy_addr   (phy_addr),
        .reg_addr   (reg_addr),
        .div_sel    (div_sel),
        .data_q     (data_q),
        .cmd_rdata  (cmd_rdata),
        .data_rdata (data_rdata)
    );

    mdio_clkgen #(
        .BASE_LOG2 (BASE_LOG2),
        .SEL_W     (DIVSEL_W)
    ) i_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .sel       (div_sel),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_engine i_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .op_wr     (op_wr),
        .phy_addr  (phy_addr),
        .reg_addr  (reg_addr),
        .wdata     (data_q),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .run       (run),
        .done      (done),
        .rdata     (rd_result),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );
endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        wr_sel,
    input logic [31:0] wr_data,
    input logic [31:0] cmd_rdata,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    logic busy;
    assign busy = cmd_rdata[0];

    assert_start_sets_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && wr_data[0] && !busy) |=> busy);

    assert_mdc_only_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> busy);

    assert_pin_quiet_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    assert_cmd_hold_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cmd_rdata));

    assert_idle_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdio_oe && !mdc));
endmodule

bind mdio_mgmt_master mdio_mgmt_checker i_mdio_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .cmd_rdata (cmd_rdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/test_mdio_mgmt_master.sv
module test_mdio_mgmt_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] cmd_rdata, data_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit timed_out = 0;

    // PHY model
    logic        phy_drv = 1'b1;
    logic [15:0] phy_val = '0;
    logic [63:0] cap_line, cap_oe;
    int          rcnt = 0;

    assign mdio_i = mdio_oe ? mdio_o : phy_drv;

    always #5 clk = !clk;

    mdio_mgmt_master i_mdio_mgmt_master (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cmd_rdata(cmd_rdata), .data_rdata(data_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always @(posedge mdc) begin
        cap_line = {cap_line[62:0], mdio_i};
        cap_oe   = {cap_oe[62:0], mdio_oe};
        rcnt     = rcnt + 1;
    end

    always @(negedge mdc) begin
        if (rcnt >= 48 && rcnt < 64) phy_drv = phy_val[63 - rcnt];
        else                         phy_drv = 1'b1;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !timed_out) begin
            timed_out = 1;
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: act=%0d cycles exp=<150000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic sel, input logic [31:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] mk_cmd(input logic wr, input logic [4:0] phy,
                                           input logic [4:0] rg, input logic [1:0] dv);
        return {10'b0, dv, 3'b0, phy, 3'b0, rg, 2'b0, wr, 1'b1};
    endfunction

    task automatic wait_idle(output int busy_cycles);
        busy_cycles = 0;
        while (cmd_rdata[0] && busy_cycles < 20000) begin
            @(negedge clk);
            busy_cycles = busy_cycles + 1;
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 cmd", {32'b0, cmd_rdata}, 64'd0);
        chk("R1 data", {32'b0, data_rdata}, 64'd0);
        chk("R1 pins", {62'b0, mdc, mdio_oe}, 64'd0);
    endtask

    task automatic t_write_div16;
        int bc;
        logic [63:0] exp;
        reg_write(1'b1, 32'hFFFF_A5C3);
        chk("R9 upper zero", {32'b0, data_rdata}, 64'h0000_A5C3);
        rcnt = 0;
        reg_write(1'b0, mk_cmd(1'b1, 5'd9, 5'd22, 2'd0));
        chk("R3 busy set", {63'b0, cmd_rdata[0]}, 64'd1);
        chk("R2 layout", {32'b0, cmd_rdata}, {32'b0, mk_cmd(1'b1, 5'd9, 5'd22, 2'd0)});
        wait_idle(bc);
        exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd9, 5'd22, 2'b10, 16'hA5C3};
        chk("R5 write frame", cap_line, exp);
        chk("R5 64 clocks", 64'(rcnt), 64'd64);
        chk("R5 duration", 64'((bc >= 1024) && (bc <= 1028)), 64'd1);
        chk("R3 busy cleared", {63'b0, cmd_rdata[0]}, 64'd0);
        chk("R10 pins idle", {62'b0, mdc, mdio_oe}, 64'd0);
    endtask

    task automatic t_read(input logic [1:0] dv, input logic [15:0] val);
        int bc;
        int hi;
        phy_val = val;
        rcnt = 0;
        reg_write(1'b0, mk_cmd(1'b0, 5'd17, 5'd3, dv));
        hi = 0;
        while (!mdc) @(negedge clk);
        while (mdc) begin hi = hi + 1; @(negedge clk); end
        chk("R4 high phase", 64'(hi), 64'(1 << (dv + 3)));
        wait_idle(bc);
        chk("R6 read header", cap_line[63:18],
            {32'hFFFF_FFFF, 2'b01, 2'b10, 5'd17, 5'd3});
        chk("R6 release", {cap_oe[63:18] == 46'h3FFF_FFFF_FFFF, cap_oe[17:0] == 18'd0},
            64'd3);
        chk("R6 read result", {32'b0, data_rdata}, {48'b0, val});
        chk("R9 upper zero read", {48'b0, data_rdata[31:16]}, 64'd0);
    endtask

    task automatic t_busy_ignore;
        int bc;
        logic [63:0] exp;
        reg_write(1'b1, 32'h0000_1234);
        rcnt = 0;
        reg_write(1'b0, mk_cmd(1'b1, 5'd3, 5'd7, 2'd0));
        repeat (300) @(negedge clk);
        reg_write(1'b0, mk_cmd(1'b0, 5'd30, 5'd31, 2'd3));
        wait_idle(bc);
        exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd3, 5'd7, 2'b10, 16'h1234};
        chk("R8 frame unchanged", cap_line, exp);
        chk("R8 fields unchanged", {32'b0, cmd_rdata},
            {32'b0, mk_cmd(1'b1, 5'd3, 5'd7, 2'd0) & 32'hFFFF_FFFE});
        repeat (200) @(negedge clk);
        chk("R8 no second frame", {61'b0, cmd_rdata[0], mdc, 1'b0} | 64'(rcnt - 64), 64'd0);
    endtask

    task automatic t_no_start;
        rcnt = 0;
        reg_write(1'b0, mk_cmd(1'b1, 5'd21, 5'd10, 2'd2) & 32'hFFFF_FFFE);
        chk("R3 bit0 clear fields", {32'b0, cmd_rdata},
            {32'b0, mk_cmd(1'b1, 5'd21, 5'd10, 2'd2) & 32'hFFFF_FFFE});
        repeat (100) @(negedge clk);
        chk("R3 bit0 clear idle", {62'b0, mdc, cmd_rdata[0]} | 64'(rcnt), 64'd0);
    endtask

    initial begin
        cap_line = '0;
        cap_oe = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_div16();
        t_read(2'd0, 16'hBEEF);
        t_read(2'd1, 16'h0001);
        t_read(2'd3, 16'h8F70);
        t_busy_ignore();
        t_no_start();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule